// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the hardware half of a receive ring that it shares with a host processor through a simple word-wide memory port. The host lays out a ring of 16-byte descriptors. Each descriptor holds a buffer pointer in its first word, a status word with an ownership flag and a negative buffer size in its second word, and a count word in its third. The engine stays idle until it gets a start pulse. At that pulse it captures the ring base and the ring length. The length is given as a log2 value in the upper nibble of an 8-bit field. The engine then points at the first descriptor.

Each frame arrives as a byte stream with start and end markers and three error flags. When a frame begins, the engine reads the current descriptor's status word. If the hardware owns the descriptor, the engine fetches the buffer pointer. It packs the frame bytes little-endian into 32-bit words and writes them into the buffer, discarding any bytes that do not fit. It then writes the count word and after it the status word. The written status word has ownership cleared, the start and end markers set, and the error summary. The engine pulses a receive interrupt and moves to the next descriptor, wrapping at the end of the ring. If the host still owns the descriptor, the engine consumes the whole frame, writes nothing, leaves the ring position where it was and pulses a missed-frame interrupt.

The byte input is valid/ready. A beat is taken on a cycle where `s_valid` and `s_ready` are both high. The source must hold a beat and its flags stable until it is taken. `s_ready` is low before the first start pulse, while a descriptor is being fetched and while results are being written back. Between frames, `s_ready` is high only for a beat without the start marker. Such a stray beat is discarded. A beat that carries the start marker waits until the descriptor has been read. Once a frame has begun, every cycle takes a byte.

Top module: `rxring_engine`

## Requirements
- R1: A start pulse captures `ring_base` (low 4 bits forced to zero) and `ring_len`, and makes the next frame use the descriptor at the ring base. The descriptor index is 0 at that point.
- R2: With n = `ring_len[7:4]` (the low nibble is ignored), the ring holds 2^n descriptors at base + 16*i. The index advances by one after each stored frame and wraps from 2^n-1 back to 0.
- R3: At a frame start the engine reads the status word at descriptor offset 4. If bit 31 (ownership) is set, it reads the buffer pointer at offset 0 and uses its upper bits as a word-aligned byte address.
- R4: Frame bytes are written little-endian into consecutive words from the buffer pointer. The first byte goes in bits 7:0. A final partial word is zero-padded. No word beyond the last one holding a stored byte is written.
- R5: The count word at offset 8 is written with the number of stored bytes in bits 11:0 and zeros above. This write happens in the cycle before the status-word write.
- R6: The status word written back has bit 31 clear, bit 25 (start of packet) and bit 24 (end of packet) set, bits 23:16 zero, and bits 15:0 equal to the buffer-size field that was read.
- R7: Status bit 29 is set if `s_frame_err` was high on any beat of the frame. Bit 28 does the same for `s_ovfl_err` and bit 27 for `s_crc_err`. Bit 30 is the OR of bits 29 to 26.
- R8: The buffer holds the two's-complement negative of status bits 15:0 in bytes (a field of 0 gives a size of 0). Bytes beyond that size are dropped, and bit 26 (buffer error) is set. The count word then reports only the stored bytes.
- R9: `rx_int` is a one-cycle pulse in the cycle after the status-word write.
- R10: If the status word read at a frame start has bit 31 clear, the frame is consumed and no memory write occurs. `miss_int` pulses for one cycle after the last beat, and the next frame uses the same descriptor.
- R11: `s_ready` is low before the first start pulse and during descriptor reads and write-back. A beat without the start marker that arrives between frames is taken and has no effect on memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Pulse: capture ring base and length, rewind to descriptor 0 |
| ring_base | input | AW | Byte address of the ring |
| ring_len | input | 8 | Ring log2 length in bits 7:4 |
| s_valid | input | 1 | Byte beat valid |
| s_ready | output | 1 | Byte beat taken when high together with s_valid |
| s_data | input | 8 | Frame byte |
| s_first | input | 1 | Beat is the first of a frame |
| s_last | input | 1 | Beat is the last of a frame |
| s_frame_err | input | 1 | Framing error seen on this beat |
| s_ovfl_err | input | 1 | Overflow error seen on this beat |
| s_crc_err | input | 1 | CRC error seen on this beat |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| rx_int | output | 1 | Receive-complete pulse |
| miss_int | output | 1 | Missed-frame pulse |

## Verification
The bench sweeps frame lengths from one byte up across all alignments of the last word. A wrong lane select or missing zero-padding would corrupt the final word, and an extra write would overwrite the guard word placed after the data. Truncation is exercised with sizes of 32, 5 and 0 bytes. A design that ignored the negative size would overrun the guard word or report the full frame length instead of the stored count. Two ring lengths and a mid-ring restart are used, so a missing wrap or a start pulse that did not rewind would read an unarmed descriptor and report a missed frame. A host-owned descriptor, a stray beat between frames and an error flag raised only on the first beat are each covered. A design that wrote anyway would show it in the descriptor or buffer, a design that stored the stray byte would shift every data word, and a design that latched flags only on the last beat would lose the CRC bit.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_WAIT,
    ST_RD_STAT,
    ST_GET_STAT,
    ST_RD_BUF,
    ST_GET_BUF,
    ST_FILL,
    ST_DISCARD,
    ST_FLUSH,
    ST_PUT_CNT,
    ST_PUT_STAT
  } rxr_state_e;

  // Status word bit positions (decoded by host software)
  localparam int OWN_POS  = 31;
  localparam int ERR_POS  = 30;
  localparam int FRAM_POS = 29;
  localparam int OFLO_POS = 28;
  localparam int CRC_POS  = 27;
  localparam int BUFF_POS = 26;
  localparam int STP_POS  = 25;
  localparam int ENP_POS  = 24;

  localparam int CNT_W = 12;
  localparam int SIZE_W = 16;

  // Word offsets inside a 16-byte descriptor
  localparam logic [3:0] OFS_PTR  = 4'h0;
  localparam logic [3:0] OFS_STAT = 4'h4;
  localparam logic [3:0] OFS_CNT  = 4'h8;

endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int AW   = 16,
  parameter int IDXW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base_in,
  input  logic [3:0]    log_len,
  input  logic          advance,
  output logic [AW-1:0] desc_addr
);
  localparam logic [3:0] NMAX = (IDXW > 15) ? 4'd15 : 4'(IDXW);

  logic [AW-1:0]   base_q;
  logic [3:0]      n_q;
  logic [IDXW-1:0] idx_q;
  logic [IDXW-1:0] wrap_mask;
  logic            unused_low;

  assign unused_low = ^base_in[3:0];
  assign wrap_mask  = IDXW'((33'd1 << n_q) - 33'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      n_q    <= '0;
      idx_q  <= '0;
    end else if (load) begin
      base_q <= {base_in[AW-1:4], 4'b0000};
      n_q    <= (log_len > NMAX) ? NMAX : log_len;
      idx_q  <= '0;
    end else if (advance) begin
      idx_q <= (idx_q + 1'b1) & wrap_mask;
    end
  end

  assign desc_addr = base_q + AW'({idx_q, 4'b0000});

endmodule

// File: rtl/rxr_packer.sv
module rxr_packer #(
  parameter int OFSW = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            push,
  input  logic [7:0]      din,
  input  logic            last,
  output logic            pend,
  output logic [31:0]     word,
  output logic [OFSW-1:0] wofs
);
  logic [31:0]     cur;
  logic [1:0]      pos;
  logic [OFSW-1:0] ofs_cnt;
  logic [31:0]     lane_val;
  logic [31:0]     merged;
  logic            emit;

  assign lane_val = {24'b0, din} << {pos, 3'b000};
  assign merged   = cur | (push ? lane_val : 32'b0);
  assign emit     = (push && (pos == 2'd3 || last)) || (last && !push && pos != 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur     <= '0;
      pos     <= '0;
      ofs_cnt <= '0;
      pend    <= 1'b0;
      word    <= '0;
      wofs    <= '0;
    end else if (clr) begin
      cur     <= '0;
      pos     <= '0;
      ofs_cnt <= '0;
      pend    <= 1'b0;
    end else begin
      pend <= emit;
      if (emit) begin
        word    <= merged;
        wofs    <= ofs_cnt;
        ofs_cnt <= ofs_cnt + 1'b1;
        cur     <= '0;
        pos     <= '0;
      end else if (push) begin
        cur <= merged;
        pos <= pos + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rxr_status.sv
module rxr_status
  import rxr_pkg::*;
(
  input  logic              fe,
  input  logic              oe,
  input  logic              ce,
  input  logic              be,
  input  logic [SIZE_W-1:0] size_field,
  input  logic [SIZE_W-1:0] stored,
  output logic [31:0]       stat_word,
  output logic [31:0]       cnt_word
);
  logic unused_hi;
  assign unused_hi = ^stored[SIZE_W-1:CNT_W];

  always_comb begin
    stat_word                   = '0;
    stat_word[OWN_POS]          = 1'b0;
    stat_word[FRAM_POS]         = fe;
    stat_word[OFLO_POS]         = oe;
    stat_word[CRC_POS]          = ce;
    stat_word[BUFF_POS]         = be;
    stat_word[ERR_POS]          = fe | oe | ce | be;
    stat_word[STP_POS]          = 1'b1;
    stat_word[ENP_POS]          = 1'b1;
    stat_word[SIZE_W-1:0]       = size_field;
    cnt_word                    = '0;
    cnt_word[CNT_W-1:0]         = stored[CNT_W-1:0];
  end

endmodule

// File: rtl/rxring_engine.sv
module rxring_engine
  import rxr_pkg::*;
#(
  parameter int AW   = 16,
  parameter int IDXW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] ring_base,
  input  logic [7:0]    ring_len,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [7:0]    s_data,
  input  logic          s_first,
  input  logic          s_last,
  input  logic          s_frame_err,
  input  logic          s_ovfl_err,
  input  logic          s_crc_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          rx_int,
  output logic          miss_int
);
  localparam int OFSW = AW - 2;

  rxr_state_e st, st_nx;

  logic [SIZE_W-1:0] size_field_q;
  logic [SIZE_W-1:0] size_q;
  logic [SIZE_W-1:0] stored_q;
  logic [AW-1:0]     buf_q;
  logic              fe_q, oe_q, ce_q, be_q;

  logic              accept;
  logic              keep;
  logic              drop_byte;
  logic              fill_end;
  logic              wr_md1;
  logic              wr_md2;

  logic [AW-1:0]     desc_addr;
  logic              pk_pend;
  logic [31:0]       pk_word;
  logic [OFSW-1:0]   pk_ofs;
  logic [31:0]       stat_word;
  logic [31:0]       cnt_word;
  logic              unused_in;

  assign unused_in = ^{mem_rdata, ring_len[3:0]};

  assign accept    = s_valid && s_ready;
  assign keep      = (st == ST_FILL) && accept && (stored_q < size_q);
  assign drop_byte = (st == ST_FILL) && accept && !keep;
  assign fill_end  = (st == ST_FILL) && accept && s_last;
  assign wr_md1    = (st == ST_PUT_STAT);
  assign wr_md2    = (st == ST_PUT_CNT);

  rxr_ring_ptr #(.AW(AW), .IDXW(IDXW)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .base_in   (ring_base),
    .log_len   (ring_len[7:4]),
    .advance   (wr_md1),
    .desc_addr (desc_addr)
  );

  rxr_packer #(.OFSW(OFSW)) u_pack (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st == ST_GET_BUF),
    .push  (keep),
    .din   (s_data),
    .last  (fill_end),
    .pend  (pk_pend),
    .word  (pk_word),
    .wofs  (pk_ofs)
  );

  rxr_status u_stat (
    .fe         (fe_q),
    .oe         (oe_q),
    .ce         (ce_q),
    .be         (be_q),
    .size_field (size_field_q),
    .stored     (stored_q),
    .stat_word  (stat_word),
    .cnt_word   (cnt_word)
  );

  // Stream handshake
  always_comb begin
    case (st)
      ST_WAIT:             s_ready = s_valid && !s_first;
      ST_FILL, ST_DISCARD: s_ready = 1'b1;
      default:             s_ready = 1'b0;
    endcase
  end

  // Sequencing
  always_comb begin
    st_nx = st;
    case (st)
      ST_OFF:      st_nx = ST_OFF;
      ST_WAIT:     if (s_valid && s_first) st_nx = ST_RD_STAT;
      ST_RD_STAT:  st_nx = ST_GET_STAT;
      ST_GET_STAT: st_nx = mem_rdata[OWN_POS] ? ST_RD_BUF : ST_DISCARD;
      ST_RD_BUF:   st_nx = ST_GET_BUF;
      ST_GET_BUF:  st_nx = ST_FILL;
      ST_FILL:     if (accept && s_last) st_nx = ST_FLUSH;
      ST_DISCARD:  if (accept && s_last) st_nx = ST_WAIT;
      ST_FLUSH:    st_nx = ST_PUT_CNT;
      ST_PUT_CNT:  st_nx = ST_PUT_STAT;
      ST_PUT_STAT: st_nx = ST_WAIT;
      default:     st_nx = ST_OFF;
    endcase
    if (start) st_nx = ST_WAIT;
  end

  // Memory port
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_wdata = '0;
    case (st)
      ST_RD_STAT: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + AW'(OFS_STAT);
      end
      ST_RD_BUF: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + AW'(OFS_PTR);
      end
      ST_FILL, ST_FLUSH: begin
        mem_req   = pk_pend;
        mem_we    = pk_pend;
        mem_addr  = buf_q + AW'({pk_ofs, 2'b00});
        mem_wdata = pk_word;
      end
      ST_PUT_CNT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr + AW'(OFS_CNT);
        mem_wdata = cnt_word;
      end
      ST_PUT_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr + AW'(OFS_STAT);
        mem_wdata = stat_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_OFF;
      size_field_q <= '0;
      size_q       <= '0;
      stored_q     <= '0;
      buf_q        <= '0;
      fe_q         <= 1'b0;
      oe_q         <= 1'b0;
      ce_q         <= 1'b0;
      be_q         <= 1'b0;
      rx_int       <= 1'b0;
      miss_int     <= 1'b0;
    end else begin
      st       <= st_nx;
      rx_int   <= wr_md1;
      miss_int <= (st == ST_DISCARD) && accept && s_last;
      if (st == ST_GET_STAT) begin
        size_field_q <= mem_rdata[SIZE_W-1:0];
        size_q       <= SIZE_W'(0) - mem_rdata[SIZE_W-1:0];
      end
      if (st == ST_GET_BUF) begin
        buf_q    <= {mem_rdata[AW-1:2], 2'b00};
        stored_q <= '0;
        fe_q     <= 1'b0;
        oe_q     <= 1'b0;
        ce_q     <= 1'b0;
        be_q     <= 1'b0;
      end
      if (st == ST_FILL && accept) begin
        fe_q <= fe_q | s_frame_err;
        oe_q <= oe_q | s_ovfl_err;
        ce_q <= ce_q | s_crc_err;
        be_q <= be_q | drop_byte;
      end
      if (keep) stored_q <= stored_q + 1'b1;
    end
  end

endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          s_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          rx_int,
  input logic          miss_int,
  input logic          wr_md1,
  input logic          wr_md2
);
  logic started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else if (start) started <= 1'b1;
  end

  a_r11_idle_before_start: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !s_ready);

  a_r11_no_take_in_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_md1 || wr_md2) |-> !s_ready);

  a_r5_count_word: assert property (@(posedge clk) disable iff (!rst_n)
    wr_md2 |-> (mem_req && mem_we && mem_addr[3:0] == 4'h8 && mem_wdata[31:12] == 20'h0));

  a_r5_count_before_status: assert property (@(posedge clk) disable iff (!rst_n)
    wr_md1 |-> $past(wr_md2));

  a_r6_release_owner: assert property (@(posedge clk) disable iff (!rst_n)
    wr_md1 |-> (mem_req && mem_we && mem_addr[3:0] == 4'h4 && !mem_wdata[31]
                && mem_wdata[25] && mem_wdata[24] && mem_wdata[23:16] == 8'h00));

  a_r7_error_summary: assert property (@(posedge clk) disable iff (!rst_n)
    wr_md1 |-> (mem_wdata[30] == (|mem_wdata[29:26])));

  a_r9_int_follows_status: assert property (@(posedge clk) disable iff (!rst_n)
    rx_int |-> $past(wr_md1));

  a_r9_int_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_int |=> !rx_int);

  a_r10_miss_single: assert property (@(posedge clk) disable iff (!rst_n)
    miss_int |=> !miss_int);

  a_r10_miss_no_rx: assert property (@(posedge clk) disable iff (!rst_n)
    miss_int |-> !rx_int);

endmodule

bind rxring_engine rxr_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .s_ready   (s_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .rx_int    (rx_int),
  .miss_int  (miss_int),
  .wr_md1    (wr_md1),
  .wr_md2    (wr_md2)
);

// File: tb/rxring_engine_test.sv
`timescale 1ns/1ps
module rxring_engine_test;
  localparam int AW   = 12;
  localparam int IDXW = 4;
  localparam int RBASE = 32'h100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] ring_base = '0;
  logic [7:0]    ring_len = '0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [7:0]    s_data = '0;
  logic          s_first = 1'b0;
  logic          s_last = 1'b0;
  logic          s_frame_err = 1'b0;
  logic          s_ovfl_err = 1'b0;
  logic          s_crc_err = 1'b0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = '0;
  logic          rx_int, miss_int;

  logic          h_we = 1'b0;
  logic [9:0]    h_addr = '0;
  logic [31:0]   h_data = '0;
  logic [31:0]   mem [0:1023];

  int n_cmp = 0;
  int n_bad = 0;
  int rx_cnt = 0;
  int miss_cnt = 0;
  int rx_exp = 0;
  int miss_exp = 0;
  int idx = 0;
  int ring_n = 4;
  int fr = 0;

  always #2 clk = ~clk;

  rxring_engine #(.AW(AW), .IDXW(IDXW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ring_base(ring_base), .ring_len(ring_len),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_first(s_first), .s_last(s_last),
    .s_frame_err(s_frame_err), .s_ovfl_err(s_ovfl_err), .s_crc_err(s_crc_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rx_int(rx_int), .miss_int(miss_int)
  );

  always @(posedge clk) begin
    if (h_we) mem[h_addr] <= h_data;
    if (mem_req) begin
      if (mem_we) mem[mem_addr[AW-1:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[AW-1:2]];
    end
    if (rx_int)   rx_cnt   <= rx_cnt + 1;
    if (miss_int) miss_cnt <= miss_cnt + 1;
  end

  function automatic int bufa(int i);
    return 32'h200 + i * 32'h40;
  endfunction

  function automatic logic [7:0] byt(int f, int k);
    return 8'(f * 16 + k * 3 + 1);
  endfunction

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hw(int waddr, logic [31:0] d);
    @(negedge clk);
    h_we = 1'b1; h_addr = 10'(waddr); h_data = d;
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic arm(int i, int size, bit own);
    for (int k = 0; k < 16; k++) hw((bufa(i) >> 2) + k, 32'hDEADBEEF);
    hw((RBASE + 16 * i) >> 2, bufa(i));
    hw(((RBASE + 16 * i) >> 2) + 1, {own, 15'b0, 16'(-size)});
    hw(((RBASE + 16 * i) >> 2) + 2, 32'hFFFFFFFF);
  endtask

  task automatic send(int f, int len, bit fe, bit oe, bit ce, bit on_first);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_data  = byt(f, k);
      s_first = (k == 0);
      s_last  = (k == len - 1);
      if (on_first ? (k == 0) : (k == len - 1)) begin
        s_frame_err = fe; s_ovfl_err = oe; s_crc_err = ce;
      end else begin
        s_frame_err = 1'b0; s_ovfl_err = 1'b0; s_crc_err = 1'b0;
      end
      #1;
      while (!s_ready) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0; s_first = 1'b0; s_last = 1'b0;
    s_frame_err = 1'b0; s_ovfl_err = 1'b0; s_crc_err = 1'b0;
  endtask

  task automatic check_frame(int i, int f, int len, int size, bit fe, bit oe, bit ce);
    int stored, nw;
    bit be;
    logic [31:0] w;
    repeat (8) @(negedge clk);
    stored = (len < size) ? len : size;
    be = (len > size);
    nw = (stored + 3) / 4;
    rx_exp++;
    cmp($sformatf("R2/R6/R7/R8 status word desc %0d frame %0d", i, f),
        mem[((RBASE + 16 * i) >> 2) + 1],
        {1'b0, fe | oe | ce | be, fe, oe, ce, be, 2'b11, 8'h00, 16'(-size)});
    cmp($sformatf("R5/R8 count word desc %0d frame %0d", i, f),
        mem[((RBASE + 16 * i) >> 2) + 2], {20'b0, 12'(stored)});
    for (int j = 0; j <= nw; j++) begin
      if (j == nw) w = 32'hDEADBEEF;
      else begin
        w = '0;
        for (int b = 0; b < 4; b++)
          if (4 * j + b < stored) w[8*b +: 8] = byt(f, 4 * j + b);
      end
      cmp($sformatf("R3/R4 buffer word %0d desc %0d frame %0d", j, i, f),
          mem[(bufa(i) >> 2) + j], w);
    end
    cmp($sformatf("R9 receive pulses after frame %0d", f), 32'(rx_cnt), 32'(rx_exp));
    idx = (idx + 1) % ring_n;
  endtask

  task automatic frame(int len, int size, bit fe, bit oe, bit ce, bit on_first);
    fr++;
    arm(idx, size, 1'b1);
    send(fr, len, fe, oe, ce, on_first);
    check_frame(idx, fr, len, size, fe, oe, ce);
  endtask

  task automatic pulse_start(logic [7:0] len_field, int n);
    @(negedge clk);
    ring_base = AW'(RBASE + 5);
    ring_len  = len_field;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ring_n = n;
    idx = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R11 reset s_ready", 32'(s_ready), 0);
    cmp("R11 reset mem_req", 32'(mem_req), 0);
    cmp("R9 reset rx_int", 32'(rx_int), 0);
    cmp("R10 reset miss_int", 32'(miss_int), 0);
    rst_n = 1'b1;
    @(negedge clk);
    s_valid = 1'b1; s_first = 1'b0;
    #1;
    cmp("R11 ready low before start", 32'(s_ready), 0);
    @(negedge clk);
    s_valid = 1'b0;

    // R1 / R2: four-entry ring, low nibble of length field ignored
    pulse_start(8'h2B, 4);
    for (int len = 1; len <= 12; len++)
      frame(len, 32, len[0], len[1], len[2], 1'b0);

    // R8: truncation at several sizes
    frame(40, 32, 1'b0, 1'b0, 1'b0, 1'b0);
    frame(9, 5, 1'b0, 1'b0, 1'b0, 1'b0);
    frame(7, 0, 1'b0, 1'b1, 1'b0, 1'b0);

    // R7: flag raised on first beat only is still reported
    frame(3, 32, 1'b0, 1'b0, 1'b1, 1'b1);

    // R10: descriptor still owned by host
    fr++;
    arm(idx, 32, 1'b0);
    send(fr, 6, 1'b0, 0, 0, 0);
    repeat (8) @(negedge clk);
    miss_exp++;
    cmp("R10 miss pulse count", 32'(miss_cnt), 32'(miss_exp));
    cmp("R10 no receive pulse", 32'(rx_cnt), 32'(rx_exp));
    cmp("R10 status untouched", mem[((RBASE + 16 * idx) >> 2) + 1], {16'h0000, 16'(-32)});
    cmp("R10 count untouched", mem[((RBASE + 16 * idx) >> 2) + 2], 32'hFFFFFFFF);
    cmp("R10 buffer untouched", mem[bufa(idx) >> 2], 32'hDEADBEEF);
    frame(5, 32, 1'b0, 1'b0, 1'b0, 1'b0);

    // R11: stray beat between frames is taken and discarded
    @(negedge clk);
    s_valid = 1'b1; s_first = 1'b0; s_last = 1'b0; s_data = 8'hA5;
    #1;
    cmp("R11 stray beat taken", 32'(s_ready), 1);
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    frame(6, 32, 1'b0, 1'b0, 1'b0, 1'b0);
    cmp("R11 stray no miss", 32'(miss_cnt), 32'(miss_exp));

    // R1: restart mid-ring rewinds; then R2 with a two-entry ring
    if (idx == 0) frame(2, 32, 1'b0, 1'b0, 1'b0, 1'b0);
    pulse_start(8'h1F, 2);
    for (int k = 0; k < 3; k++)
      frame(4 + k, 32, 1'b1, 1'b0, 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule